// File: doc/BRIEF.md
# Remote Register Access Decoder

This block executes register reads and writes requested by a remote host. A neighbouring protocol block strips the network headers and hands over each request as one parallel message: the UDP destination port, a 16-bit request type, a 32-bit register address and a 32-bit data word. The decoder filters on the service port and checks the request type. It then resolves the address to one of seven register regions and runs a single access on a simple select/ready register bus.

The address decode has two levels. The top nibble of the address picks either the processor-side core or the framework. For framework addresses, the next nibble picks one of its subunits: common, Ethernet, packet, application, DAC interface or ADC interface. A read produces a reply message toward the host on the same service port. The reply holds the request type, the address and the data. A write produces no reply. Several cases return a fixed filler word: reads of unused regions, and reads whose region never answers within the wait limit. Messages of an unknown type are discarded and counted.

Top module: `regacc_decoder`

## Requirements
- R1: A message whose UDP port is not 1001 is taken and discarded. It causes no bus access and no reply, and it does not change the error count.
- R2: An address whose bits [31:28] are 0x0 or 0x1 selects the core region, which is `bus_sel` bit 0.
- R3: An address whose bits [31:28] are 0x2 selects a framework subunit from bits [27:24]. Code 0x0 selects common (bit 1), 0x1 Ethernet (bit 2) and 0x2 packet (bit 3). Codes 0x4 to 0xB select application (bit 4), 0xC selects the DAC interface (bit 5) and 0xD the ADC interface (bit 6).
- R4: Top nibbles 0x3 to 0xF and framework codes 0x3, 0xE and 0xF are unused. A read of an unused address replies with 0xDEADBEEF and makes no bus access. A write to one is dropped with no bus access and no reply.
- R5: During an access, exactly one `bus_sel` bit is high. `bus_addr`, `bus_wr` and `bus_wdata` carry the request and stay constant until the cycle in which `bus_ready` is high.
- R6: A read (type 0x2000) that is answered gives a reply on `rsp_*`. The reply has port 1001, type 0x2000, the request address, and the `bus_rdata` value from the cycle in which `bus_ready` was high. It is held unchanged until `rsp_ready`.
- R7: A write (type 0x2001) performs its bus access and produces no reply.
- R8: The select stays up for at most 64 cycles. A `bus_ready` in the 64th cycle is still accepted. If no ready arrives, the access ends: a read replies with 0xDEADBEEF and a write ends silently.
- R9: A service-port message whose type is neither 0x2000 nor 0x2001 is discarded and increments `err_count`. The count saturates at its all-ones value (255).
- R10: `req_ready` is high only when no access or reply is in progress, and the bus select is low whenever `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Decoder can take a message |
| req_port | input | 16 | UDP destination port of the message |
| req_type | input | 16 | Request type code |
| req_addr | input | 32 | Register address |
| req_data | input | 32 | Write data |
| bus_sel | output | 7 | One-hot region select |
| bus_wr | output | 1 | Access is a write |
| bus_addr | output | 32 | Register address on the bus |
| bus_wdata | output | 32 | Write data on the bus |
| bus_rdata | input | 32 | Read data from the selected region |
| bus_ready | input | 1 | Selected region finishes the access |
| rsp_valid | output | 1 | Reply message present |
| rsp_ready | input | 1 | Host path takes the reply |
| rsp_port | output | 16 | UDP port of the reply |
| rsp_type | output | 16 | Echoed request type |
| rsp_addr | output | 32 | Echoed register address |
| rsp_data | output | 32 | Read data or filler word |
| err_count | output | 8 | Saturating count of rejected request types |

## Verification
The region's ready and the end of the wait window can coincide. The bench provokes this by raising `bus_ready` in exactly the 64th select cycle. The reply must then carry the region's data and not the filler word. A ready that never comes must give the filler word after exactly 64 select cycles. A bench model predicts the select pattern, the number of select cycles, the reply contents and the error count for every message, and compares them at each clock.

// File: rtl/rra_pkg.sv
package rra_pkg;
   localparam int NUM_REGIONS = 7;

   typedef enum logic [2:0] {
      RG_CORE = 3'd0,
      RG_CMN  = 3'd1,
      RG_ETH  = 3'd2,
      RG_PKT  = 3'd3,
      RG_APP  = 3'd4,
      RG_DAC  = 3'd5,
      RG_ADC  = 3'd6
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BUS   = 2'd1,
      ST_REPLY = 2'd2
   } fsm_e;
endpackage

// File: rtl/rra_addr_decode.sv
module rra_addr_decode
   import rra_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int APP_FIRST = 4,
   parameter int APP_LAST  = 11
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic                   hit,
   output logic [NUM_REGIONS-1:0] sel
);
   localparam int TOP_LSB = ADDR_W - 4;
   localparam int SUB_LSB = ADDR_W - 8;

   logic [3:0] top_nib;
   logic [3:0] sub_nib;
   region_e    region;

   assign top_nib = addr[TOP_LSB +: 4];
   assign sub_nib = addr[SUB_LSB +: 4];

   always_comb begin
      hit    = 1'b0;
      region = RG_CORE;
      case (top_nib)
         4'h0, 4'h1: hit = 1'b1;
         4'h2: begin
            if (sub_nib == 4'h0) begin
               hit = 1'b1; region = RG_CMN;
            end else if (sub_nib == 4'h1) begin
               hit = 1'b1; region = RG_ETH;
            end else if (sub_nib == 4'h2) begin
               hit = 1'b1; region = RG_PKT;
            end else if (int'(sub_nib) >= APP_FIRST && int'(sub_nib) <= APP_LAST) begin
               hit = 1'b1; region = RG_APP;
            end else if (sub_nib == 4'hC) begin
               hit = 1'b1; region = RG_DAC;
            end else if (sub_nib == 4'hD) begin
               hit = 1'b1; region = RG_ADC;
            end
         end
         default: hit = 1'b0;
      endcase
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_sel
      assign sel[r] = hit && (int'(region) == r);
   end

   if (ADDR_W < 8) begin : g_chk_addr
      $error("rra_addr_decode: ADDR_W must hold two nibbles");
   end
   if (APP_FIRST < 3 || APP_LAST > 11 || APP_FIRST > APP_LAST) begin : g_chk_app
      $error("rra_addr_decode: application code range invalid");
   end
endmodule

// File: rtl/rra_wait_timer.sv
module rra_wait_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign expire = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!expire) cnt <= cnt + 1'b1;
   end

   if (LIMIT < 2) begin : g_chk_limit
      $error("rra_wait_timer: LIMIT must be at least 2");
   end

   assert_tmo_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !run);
endmodule

// File: rtl/rra_err_count.sv
module rra_err_count #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      assign nxt = (count == MAXV) ? count : count + 1'b1;
   end else begin : g_wrap
      assign nxt = count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= nxt;
   end

   if (CNT_W < 1) begin : g_chk_w
      $error("rra_err_count: CNT_W must be positive");
   end

   if (SATURATE) begin : g_sat_chk
      assert_err_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (count == MAXV) |=> (count == MAXV));
   end
endmodule

// File: rtl/regacc_decoder.sv
module regacc_decoder
   import rra_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                TYPE_W    = 16,
   parameter int                PORT_W    = 16,
   parameter int                ERR_W     = 8,
   parameter int                WAIT_MAX  = 64,
   parameter logic [PORT_W-1:0] SVC_PORT  = 16'd1001,
   parameter logic [TYPE_W-1:0] RD_CODE   = 16'h2000,
   parameter logic [TYPE_W-1:0] WR_CODE   = 16'h2001,
   parameter logic [DATA_W-1:0] FILL_WORD = 32'hDEAD_BEEF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [PORT_W-1:0]      req_port,
   input  logic [TYPE_W-1:0]      req_type,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_data,
   output logic [NUM_REGIONS-1:0] bus_sel,
   output logic                   bus_wr,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [DATA_W-1:0]      bus_wdata,
   input  logic [DATA_W-1:0]      bus_rdata,
   input  logic                   bus_ready,
   output logic                   rsp_valid,
   input  logic                   rsp_ready,
   output logic [PORT_W-1:0]      rsp_port,
   output logic [TYPE_W-1:0]      rsp_type,
   output logic [ADDR_W-1:0]      rsp_addr,
   output logic [DATA_W-1:0]      rsp_data,
   output logic [ERR_W-1:0]       err_count
);
   fsm_e                   state;
   logic [NUM_REGIONS-1:0] sel_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      data_q;
   logic                   wr_q;
   logic [DATA_W-1:0]      rsp_data_q;

   logic                   accept, port_ok, is_rd, is_wr, type_ok;
   logic                   cmd_ok, bad_type;
   logic                   dec_hit;
   logic [NUM_REGIONS-1:0] dec_sel;
   logic                   tmo_run, tmo_expire;

   assign accept   = req_valid && (state == ST_IDLE);
   assign port_ok  = (req_port == SVC_PORT);
   assign is_rd    = (req_type == RD_CODE);
   assign is_wr    = (req_type == WR_CODE);
   assign type_ok  = is_rd || is_wr;
   assign cmd_ok   = accept && port_ok && type_ok;
   assign bad_type = accept && port_ok && !type_ok;

   rra_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr),
      .hit  (dec_hit),
      .sel  (dec_sel)
   );

   assign tmo_run = (state == ST_BUS);

   rra_wait_timer #(.LIMIT(WAIT_MAX)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tmo_run),
      .expire (tmo_expire)
   );

   rra_err_count #(.CNT_W(ERR_W), .SATURATE(1'b1)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (bad_type),
      .count (err_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sel_q      <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         wr_q       <= 1'b0;
         rsp_data_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_ok) begin
                  addr_q <= req_addr;
                  data_q <= req_data;
                  wr_q   <= is_wr;
                  sel_q  <= dec_sel;
                  if (dec_hit) begin
                     state <= ST_BUS;
                  end else if (is_rd) begin
                     rsp_data_q <= FILL_WORD;
                     state      <= ST_REPLY;
                  end
               end
            end
            ST_BUS: begin
               if (bus_ready || tmo_expire) begin
                  if (wr_q) begin
                     state <= ST_IDLE;
                  end else begin
                     rsp_data_q <= bus_ready ? bus_rdata : FILL_WORD;
                     state      <= ST_REPLY;
                  end
               end
            end
            ST_REPLY: begin
               if (rsp_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign bus_sel   = (state == ST_BUS) ? sel_q : '0;
   assign bus_wr    = wr_q;
   assign bus_addr  = addr_q;
   assign bus_wdata = data_q;
   assign rsp_valid = (state == ST_REPLY);
   assign rsp_port  = SVC_PORT;
   assign rsp_type  = RD_CODE;
   assign rsp_addr  = addr_q;
   assign rsp_data  = rsp_data_q;

   if (DATA_W < 1 || TYPE_W < 1 || PORT_W < 1) begin : g_chk_w
      $error("regacc_decoder: widths must be positive");
   end
   if (WAIT_MAX < 2) begin : g_chk_wait
      $error("regacc_decoder: WAIT_MAX must be at least 2");
   end
   if (RD_CODE == WR_CODE) begin : g_chk_codes
      $error("regacc_decoder: read and write codes must differ");
   end

   assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_sel));

   assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|bus_sel) && !bus_ready && !tmo_expire) |=>
         ($stable(bus_sel) && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr)));

   assert_idle_no_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_sel == '0));

   assert_reply_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_addr)));

   assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|bus_sel) && bus_wr) |=> !rsp_valid);

   assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != $past(err_count)) |-> $past(bad_type));
endmodule

// File: tb/regacc_decoder_test.sv
module regacc_decoder_test;
   localparam logic [31:0] RD_MASK = 32'hA5A5_0F0F;
   localparam logic [31:0] FILLER  = 32'hDEAD_BEEF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [15:0] req_port;
   logic [15:0] req_type;
   logic [31:0] req_addr;
   logic [31:0] req_data;
   logic [6:0]  bus_sel;
   logic        bus_wr;
   logic [31:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        rsp_valid;
   logic        rsp_ready;
   logic [15:0] rsp_port;
   logic [15:0] rsp_type;
   logic [31:0] rsp_addr;
   logic [31:0] rsp_data;
   logic [7:0]  err_count;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_err = 0;

   always #5 clk = ~clk;

   assign bus_rdata = bus_addr ^ RD_MASK;

   regacc_decoder uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
      .req_type(req_type), .req_addr(req_addr), .req_data(req_data),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_port(rsp_port),
      .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
      .err_count(err_count)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] model_sel(input logic [31:0] a);
      logic [3:0] hi = a[31:28];
      logic [3:0] lo = a[27:24];
      if (hi == 4'h0 || hi == 4'h1) return 7'b000_0001;
      if (hi != 4'h2) return 7'b0;
      if (lo == 4'h0) return 7'b000_0010;
      if (lo == 4'h1) return 7'b000_0100;
      if (lo == 4'h2) return 7'b000_1000;
      if (lo >= 4'h4 && lo <= 4'hB) return 7'b001_0000;
      if (lo == 4'hC) return 7'b010_0000;
      if (lo == 4'hD) return 7'b100_0000;
      return 7'b0;
   endfunction

   // lat: select cycle in which ready is raised (0 = never)
   task automatic access(input logic [15:0] port, input logic [15:0] typ,
                         input logic [31:0] addr, input logic [31:0] wdata,
                         input int lat, input int rdly, input string tag);
      logic [6:0]  es   = model_sel(addr);
      bit          good = (port == 16'd1001) && (typ == 16'h2000 || typ == 16'h2001);
      bit          rd   = (typ == 16'h2000);
      bit          answered = (lat >= 1 && lat <= 64);
      int          ecyc;
      bit          erep;
      logic [31:0] edata;
      int          seen = 0;
      if (port == 16'd1001 && !good && exp_err < 255) exp_err++;
      ecyc  = (!good || es == 7'b0) ? 0 : (answered ? lat : 64);
      erep  = good && rd;
      edata = (es != 7'b0 && answered) ? (addr ^ RD_MASK) : FILLER;
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R10 ready before request"}, 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_port = port; req_type = typ;
      req_addr = addr; req_data = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      while (bus_sel != 7'b0 && seen < 200) begin
         seen++;
         chk(bus_sel == es, {tag, " R3 select"}, 32'(bus_sel), 32'(es));
         chk(bus_addr == addr && bus_wdata == wdata && bus_wr == (typ == 16'h2001),
             {tag, " R5 bus fields"}, bus_addr, addr);
         chk(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 32'd0);
         bus_ready = (seen == lat);
         @(negedge clk);
         bus_ready = 1'b0;
      end
      chk(seen == ecyc, {tag, " R8 select cycles"}, 32'(seen), 32'(ecyc));
      chk(int'(err_count) == exp_err, {tag, " R9 error count"}, 32'(err_count), 32'(exp_err));
      if (erep) begin
         chk(rsp_valid == 1'b1, {tag, " R6 reply present"}, 32'(rsp_valid), 32'd1);
         chk(rsp_data == edata, {tag, " R6 reply data"}, rsp_data, edata);
         chk(rsp_addr == addr, {tag, " R6 reply addr"}, rsp_addr, addr);
         chk(rsp_type == 16'h2000 && rsp_port == 16'd1001, {tag, " R6 reply type/port"},
             {rsp_type, rsp_port}, {16'h2000, 16'd1001});
         for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1 && rsp_data == edata, {tag, " R6 reply held"}, rsp_data, edata);
         end
         rsp_ready = 1'b1;
         @(negedge clk);
         rsp_ready = 1'b0;
         chk(rsp_valid == 1'b0, {tag, " R6 reply retired"}, 32'(rsp_valid), 32'd0);
      end else begin
         chk(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R7 no reply"},
             32'(rsp_valid), 32'd0);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_type = '0;
      req_addr = '0; req_data = '0; bus_ready = 1'b0; rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_sel == 7'b0 && rsp_valid == 1'b0,
          "R10 reset state", {25'b0, bus_sel}, 32'd0);
      chk(err_count == 8'd0, "R9 reset count", 32'(err_count), 32'd0);

      access(16'd1001, 16'h2000, 32'h0000_0010, 32'h0, 3, 2, "R2 core read nib0");
      access(16'd1001, 16'h2000, 32'h1234_5678, 32'h0, 1, 0, "R2 core read nib1");
      for (int s = 0; s < 16; s++)
         access(16'd1001, 16'h2001, {4'h2, 4'(s), 24'h00_0004}, 32'h1111_0000 + 32'(s),
                2, 0, "R3 framework write");
      access(16'd1001, 16'h2000, 32'h2C00_0100, 32'h0, 5, 1, "R3 dac read");
      access(16'd1001, 16'h2000, 32'h2E00_0000, 32'h0, 1, 0, "R4 unused sub read");
      access(16'd1001, 16'h2000, 32'h3000_0000, 32'h0, 1, 3, "R4 unused top read");
      access(16'd1001, 16'h2000, 32'hF000_0000, 32'h0, 1, 0, "R4 unused top F read");
      access(16'd1001, 16'h2001, 32'h7000_0000, 32'h5, 1, 0, "R4 unused write");
      access(16'd1002, 16'h2000, 32'h0000_0000, 32'h0, 1, 0, "R1 wrong port read");
      access(16'd1000, 16'h1234, 32'h2000_0000, 32'h0, 1, 0, "R1 wrong port bad type");
      access(16'd1001, 16'h2002, 32'h0000_0000, 32'h0, 1, 0, "R9 bad type");
      access(16'd1001, 16'h2000, 32'h2100_0040, 32'h0, 0, 0, "R8 read timeout");
      access(16'd1001, 16'h2000, 32'h2500_0080, 32'h0, 64, 0, "R8 ready at limit");
      access(16'd1001, 16'h2000, 32'h2D00_0000, 32'h0, 63, 0, "R8 ready before limit");
      access(16'd1001, 16'h2001, 32'h2200_0000, 32'hCAFE, 0, 0, "R7 write timeout");
      access(16'd1001, 16'h2001, 32'h0100_0000, 32'hBEEF, 4, 0, "R7 core write");
      for (int i = 0; i < 258; i++)
         access(16'd1001, 16'h0000, 32'h0, 32'h0, 1, 0, "R9 saturation");
      access(16'd1001, 16'h2000, 32'h2B00_0000, 32'h0, 2, 0, "R6 read after errors");

      summary();
      $finish;
   end
endmodule